// File: doc/BRIEF.md
# Round-Robin Duplicate Low-Pass Filter Checker

This block watches a bank of per-channel first-order digital low-pass filters while the main ADC converts. One shared reference filter is laid beside one channel filter at a time. Both filters take the same ADC samples, and every output pair is compared. The checker visits each voltage channel and then one auxiliary current channel, and then wraps around. It keeps going for as long as the ADC runs. Any difference raises a sticky fail flag. A done flag reports that every voltage-channel filter has been visited at least once.

A state machine orders the work. In `IDLE` the ADC is stopped. In `SEED` the reference filter is loaded from the selected channel's present output. In `WARM` the first samples after the seed are discarded. In `CMP` a set number of output pairs is compared. In `NEXT` the channel pointer moves on. The transitions are:
- IDLE→SEED when the ADC runs.
- SEED→WARM after one cycle.
- WARM→CMP on the last warm-up sample.
- CMP→NEXT on the last comparison.
- NEXT→SEED after one cycle.
- Every state→IDLE when the ADC stops.

The reference filter can be deliberately corrupted to prove that the checker itself works. When the inject request is set and the ADC is restarted, the least significant bit of the reference output is inverted. Every comparison then fails until the request is dropped.

Top module: `lpf_rr_checker`

## Requirements
- R1: After reset `filt_fail`=0, `vs_done`=0 and `chk_chan`=0.
- R2: Channels 0 to NUM_VS-1 are voltage channels and channel NUM_VS is the auxiliary channel. Channel c occupies bits [c*DATA_W +: DATA_W] of `smp_bus` and `filt_bus`. `chk_chan` steps 0,1,…,NUM_VS, then wraps to 0. Each channel takes WARMUP+COMPARE_N samples before the pointer advances.
- R3: The first WARMUP samples after a channel is seeded are never compared. A diverging channel raises no fail until the (WARMUP+1)-th sample.
- R4: A mismatch on any compared output pair of any channel, the auxiliary channel included, sets `filt_fail`. The flag stays set, even across an ADC stop, until cleared.
- R5: `vs_done` sets when channel NUM_VS-1 finishes its comparisons. It clears one cycle after `adc_run` falls.
- R6: While `adc_run`=0 nothing is compared and `chk_chan` returns to 0. Each restart begins at channel 0.
- R7: If `inj_req`=1 when `adc_run` rises, the reference output is corrupted and the next comparison fails. Raising `inj_req` while the ADC already runs has no effect until a restart.
- R8: Clearing `inj_req` ends the injection on the next cycle.
- R9: A `fail_clr` pulse clears `filt_fail`. A mismatch in the same cycle wins.
- R10: Channel filters that behave correctly never cause a fail. The reference is bit-exact to y += (x - y) >>> SHIFT_K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_run | input | 1 | Main ADC running |
| smp_valid | input | 1 | One-cycle strobe: new sample on every channel |
| smp_bus | input | NCH*DATA_W | ADC samples, channel c at [c*DATA_W +: DATA_W] |
| filt_bus | input | NCH*DATA_W | Registered channel filter outputs, same packing |
| inj_req | input | 1 | Fault-inject request, armed at ADC start |
| fail_clr | input | 1 | Write-1-to-clear pulse for `filt_fail` |
| filt_fail | output | 1 | Sticky filter mismatch flag |
| vs_done | output | 1 | Every voltage channel checked at least once |
| chk_chan | output | CH_W | Channel now under check |

## Verification
A sample strobed at edge E0 is compared in the cycle that follows. `filt_fail` therefore changes at E1. A finished channel moves `chk_chan` and may set `vs_done` at E2, and an `adc_run` drop clears both at the next edge. The bench spaces samples four cycles apart and samples outputs at the falling edge after the third edge past each strobe, so every result is already settled. The clear-versus-set race is checked by driving `fail_clr` exactly in the comparison cycle.

// File: rtl/lpfchk_pkg.sv
package lpfchk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEED = 3'd1,
        ST_WARM = 3'd2,
        ST_CMP  = 3'd3,
        ST_NEXT = 3'd4
    } chk_state_e;

endpackage

// File: rtl/lpfchk_ref_filter.sv
module lpfchk_ref_filter #(
    parameter int DATA_W  = 16,
    parameter int SHIFT_K = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic [DATA_W-1:0] seed,
    input  logic [DATA_W-1:0] sample,
    input  logic              inj,
    output logic [DATA_W-1:0] ref_out
);
    localparam int DIFF_W = DATA_W + 2;

    logic [DATA_W-1:0]        ref_q;
    logic [DATA_W-1:0]        base;
    logic [DATA_W-1:0]        stepped;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] delta;

    // A step in the seed cycle starts from the seed, as the channel filter does.
    always_comb begin
        base    = load ? seed : ref_q;
        diff    = $signed({2'b00, sample}) - $signed({2'b00, base});
        delta   = diff >>> SHIFT_K;
        stepped = base + DATA_W'($unsigned(delta));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (step_en) begin
            ref_q <= stepped;
        end else if (load) begin
            ref_q <= seed;
        end
    end

    // Injection flips the output only; the filter state stays clean.
    assign ref_out = ref_q ^ {{(DATA_W-1){1'b0}}, inj};

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step_en |=> $stable(ref_q)); // R10

endmodule

// File: rtl/lpfchk_inject.sv
module lpfchk_inject (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_run,
    input  logic inj_req,
    output logic inj_on
);
    logic run_d;
    logic inj_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_d <= 1'b0;
        end else begin
            run_d <= adc_run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inj_q <= 1'b0;
        end else if (!inj_req) begin
            inj_q <= 1'b0;
        end else if (adc_run && !run_d) begin
            inj_q <= 1'b1;
        end
    end

    assign inj_on = inj_q;

    AST_INJ_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        adc_run && !run_d && inj_req |=> inj_q); // R7
    AST_INJ_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_q) |-> $past(adc_run && !run_d)); // R7
    AST_INJ_END: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_req |=> !inj_q); // R8

endmodule

// File: rtl/lpfchk_sched.sv
module lpfchk_sched
    import lpfchk_pkg::*;
#(
    parameter int NUM_VS    = 4,
    parameter int NCH       = NUM_VS + 1,
    parameter int WARMUP    = 4,
    parameter int COMPARE_N = 3,
    parameter int CH_W      = $clog2(NCH),
    parameter int CNT_W     = $clog2(((WARMUP > COMPARE_N) ? WARMUP : COMPARE_N) + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adc_run,
    input  logic            smp_valid,
    output logic [CH_W-1:0] chan,
    output logic            ref_load,
    output logic            ref_step,
    output logic            cmp_en,
    output logic            done
);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARMUP - 1);
    localparam logic [CNT_W-1:0] CMP_LAST  = CNT_W'(COMPARE_N - 1);
    localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(NCH - 1);
    localparam logic [CH_W-1:0]  VS_LAST   = CH_W'(NUM_VS - 1);

    chk_state_e       state_q;
    chk_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ptr_q;
    logic             pend_q;
    logic             done_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!adc_run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_SEED;
                ST_SEED: state_d = ST_WARM;
                ST_WARM: if (smp_valid && cnt_q == WARM_LAST) state_d = ST_CMP;
                ST_CMP:  if (pend_q && cnt_q == CMP_LAST) state_d = ST_NEXT;
                ST_NEXT: state_d = ST_SEED;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        ref_load = 1'b0;
        ref_step = 1'b0;
        cmp_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEED: begin
                ref_load = adc_run;
                ref_step = adc_run && smp_valid;
            end
            ST_WARM: ref_step = adc_run && smp_valid;
            ST_CMP: begin
                ref_step = adc_run && smp_valid;
                cmp_en   = adc_run && pend_q;
            end
            ST_NEXT: ;
            default: ;
        endcase
    end

    // Sample and comparison counter, pending-compare marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_WARM && smp_valid) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (cmp_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            pend_q <= adc_run && smp_valid && state_q == ST_CMP && state_d == ST_CMP;
        end
    end

    // Channel pointer and coverage flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else if (!adc_run) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else if (state_q == ST_NEXT) begin
            ptr_q <= (ptr_q == CH_LAST) ? '0 : ptr_q + 1'b1;
            if (ptr_q == VS_LAST) begin
                done_q <= 1'b1;
            end
        end
    end

    assign chan = ptr_q;
    assign done = done_q;

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= CH_LAST); // R2
    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> (ptr_q == '0) || (ptr_q == $past(ptr_q) + 1'b1)); // R2
    AST_CMP_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP) && ($past(state_q) != ST_CMP) |-> $past(state_q) == ST_WARM); // R3
    AST_IDLE_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_run |=> ptr_q == '0); // R6
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_run |=> !done_q); // R5

endmodule

// File: rtl/lpf_rr_checker.sv
module lpf_rr_checker
    import lpfchk_pkg::*;
#(
    parameter int NUM_VS    = 4,
    parameter int DATA_W    = 16,
    parameter int SHIFT_K   = 2,
    parameter int WARMUP    = 4,
    parameter int COMPARE_N = 3,
    parameter int NCH       = NUM_VS + 1,
    parameter int CH_W      = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adc_run,
    input  logic                  smp_valid,
    input  logic [NCH*DATA_W-1:0] smp_bus,
    input  logic [NCH*DATA_W-1:0] filt_bus,
    input  logic                  inj_req,
    input  logic                  fail_clr,
    output logic                  filt_fail,
    output logic                  vs_done,
    output logic [CH_W-1:0]       chk_chan
);
    localparam int SLOTS = 1 << CH_W;

    logic [DATA_W-1:0] smp_arr  [SLOTS];
    logic [DATA_W-1:0] filt_arr [SLOTS];
    logic [DATA_W-1:0] sel_smp;
    logic [DATA_W-1:0] sel_filt;
    logic [DATA_W-1:0] ref_out;
    logic [CH_W-1:0]   chan;
    logic              ref_load;
    logic              ref_step;
    logic              cmp_en;
    logic              inj_on;
    logic              mismatch;
    logic              fail_q;

    // Unpack channels; unused pointer codes read as zero
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NCH) begin : g_live
            assign smp_arr[g]  = smp_bus[g*DATA_W +: DATA_W];
            assign filt_arr[g] = filt_bus[g*DATA_W +: DATA_W];
        end else begin : g_pad
            assign smp_arr[g]  = '0;
            assign filt_arr[g] = '0;
        end
    end

    assign sel_smp  = smp_arr[chan];
    assign sel_filt = filt_arr[chan];

    lpfchk_sched #(
        .NUM_VS    (NUM_VS),
        .NCH       (NCH),
        .WARMUP    (WARMUP),
        .COMPARE_N (COMPARE_N),
        .CH_W      (CH_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_run   (adc_run),
        .smp_valid (smp_valid),
        .chan      (chan),
        .ref_load  (ref_load),
        .ref_step  (ref_step),
        .cmp_en    (cmp_en),
        .done      (vs_done)
    );

    lpfchk_inject u_inject (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_run (adc_run),
        .inj_req (inj_req),
        .inj_on  (inj_on)
    );

    lpfchk_ref_filter #(
        .DATA_W  (DATA_W),
        .SHIFT_K (SHIFT_K)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ref_load),
        .step_en (ref_step),
        .seed    (sel_filt),
        .sample  (sel_smp),
        .inj     (inj_on),
        .ref_out (ref_out)
    );

    assign mismatch = cmp_en && (ref_out != sel_filt);

    // Sticky fail flag: a mismatch wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (mismatch) begin
            fail_q <= 1'b1;
        end else if (fail_clr) begin
            fail_q <= 1'b0;
        end
    end

    assign filt_fail = fail_q;
    assign chk_chan  = chan;

    AST_FAIL_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && (ref_out != sel_filt) |=> filt_fail); // R4
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        filt_fail && !fail_clr |=> filt_fail); // R4
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fail_clr && !cmp_en |=> !filt_fail); // R9

endmodule

// File: tb/lpf_rr_checker_tb_top.sv
module lpf_rr_checker_tb_top;
    localparam int NUM_VS = 4;
    localparam int NCH    = NUM_VS + 1;
    localparam int DW     = 16;
    localparam int K      = 2;
    localparam int CH_W   = 3;

    // Vector: {inj[16], stuck_ch[15:13] (7 = none), samples[12:5], fail[4], done[3], chan[2:0]}
    localparam logic [16:0] VECS [12] = '{
        {1'b0, 3'd7, 8'd27, 1'b0, 1'b0, 3'd3},  // R2 R10
        {1'b0, 3'd7, 8'd28, 1'b0, 1'b1, 3'd4},  // R5
        {1'b0, 3'd7, 8'd35, 1'b0, 1'b1, 3'd0},  // R2 wrap
        {1'b0, 3'd7, 8'd7,  1'b0, 1'b0, 3'd1},  // R2
        {1'b0, 3'd0, 8'd4,  1'b0, 1'b0, 3'd0},  // R3
        {1'b0, 3'd0, 8'd5,  1'b1, 1'b0, 3'd0},  // R3 R4
        {1'b0, 3'd2, 8'd14, 1'b0, 1'b0, 3'd2},  // R4
        {1'b0, 3'd2, 8'd21, 1'b1, 1'b0, 3'd3},  // R4
        {1'b0, 3'd4, 8'd28, 1'b0, 1'b1, 3'd4},  // R4 aux
        {1'b0, 3'd4, 8'd35, 1'b1, 1'b1, 3'd0},  // R4 aux
        {1'b1, 3'd7, 8'd4,  1'b0, 1'b0, 3'd0},  // R7
        {1'b1, 3'd7, 8'd5,  1'b1, 1'b0, 3'd0}   // R7
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                adc_run = 1'b0;
    logic                smp_valid = 1'b0;
    logic                inj_req = 1'b0;
    logic                fail_clr = 1'b0;
    logic [NCH*DW-1:0]   smp_bus;
    logic [NCH*DW-1:0]   filt_bus;
    logic                filt_fail;
    logic                vs_done;
    logic [CH_W-1:0]     chk_chan;

    logic [DW-1:0]       xs [NCH];
    logic [DW-1:0]       ym [NCH];
    logic                stuck [NCH];
    int                  smp_n = 0;
    int                  n_tests = 0;
    int                  n_fail = 0;

    always #5 clk = ~clk;

    lpf_rr_checker #(.NUM_VS(NUM_VS), .DATA_W(DW), .SHIFT_K(K)) dut_i (
        .clk(clk), .rst_n(rst_n), .adc_run(adc_run), .smp_valid(smp_valid),
        .smp_bus(smp_bus), .filt_bus(filt_bus), .inj_req(inj_req),
        .fail_clr(fail_clr), .filt_fail(filt_fail), .vs_done(vs_done),
        .chk_chan(chk_chan)
    );

    // Model of the external channel filters
    function automatic logic [DW-1:0] mdl_step(input logic [DW-1:0] y, input logic [DW-1:0] x);
        logic signed [DW+1:0] d;
        d = $signed({2'b00, x}) - $signed({2'b00, y});
        d = d >>> K;
        return y + DW'($unsigned(d));
    endfunction

    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) ym[c] <= '0;
            else if (smp_valid && !stuck[c]) ym[c] <= mdl_step(ym[c], xs[c]);
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            smp_bus[c*DW +: DW]  = xs[c];
            filt_bus[c*DW +: DW] = ym[c];
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic put_sample();
        for (int c = 0; c < NCH; c++) begin
            xs[c] = DW'((smp_n * 1237 + c * 4099) ^ ((smp_n % 2 == 1) ? 16'hC000 : 16'h0000));
        end
        smp_n++;
        smp_valid = 1'b1;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            put_sample();
            @(posedge clk); @(negedge clk);
            smp_valid = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic restart(input logic inj, input int stuck_ch);
        adc_run = 1'b0;
        inj_req = inj;
        for (int c = 0; c < NCH; c++) stuck[c] = (c == stuck_ch);
        repeat (2) @(posedge clk);
        @(negedge clk); fail_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        fail_clr = 1'b0;
        adc_run = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin xs[c] = '0; stuck[c] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 fail", int'(filt_fail), 0);
        chk("R1 done", int'(vs_done), 0);
        chk("R1 chan", int'(chk_chan), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int v = 0; v < 12; v++) begin
            restart(VECS[v][16], int'(VECS[v][15:13]));
            send(int'(VECS[v][12:5]));
            chk($sformatf("R4/R10 fail vec%0d", v), int'(filt_fail), int'(VECS[v][4]));
            chk($sformatf("R5 done vec%0d", v), int'(vs_done), int'(VECS[v][3]));
            chk($sformatf("R2 chan vec%0d", v), int'(chk_chan), int'(VECS[v][2:0]));
        end

        // R5/R6: stopping the ADC drops done and resets the pointer
        restart(1'b0, 7);
        send(28);
        chk("R5 done set", int'(vs_done), 1);
        adc_run = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R5 done drop", int'(vs_done), 0);
        chk("R6 chan zero", int'(chk_chan), 0);

        // R4 sticky across stop, R9 clear
        restart(1'b0, 0);
        send(5);
        adc_run = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 sticky", int'(filt_fail), 1);
        fail_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        fail_clr = 1'b0;
        chk("R9 cleared", int'(filt_fail), 0);

        // R9: mismatch in the clear cycle wins
        restart(1'b1, 7);
        send(4);
        put_sample();
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0;
        fail_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        fail_clr = 1'b0;
        chk("R9 set wins", int'(filt_fail), 1);
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R7: request raised mid-run has no effect
        restart(1'b0, 7);
        inj_req = 1'b1;
        send(10);
        chk("R7 mid-run", int'(filt_fail), 0);
        restart(1'b1, 7);
        send(5);
        chk("R7 restart", int'(filt_fail), 1);

        // R8: dropping the request ends the injection
        inj_req = 1'b0;
        fail_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        fail_clr = 1'b0;
        send(10);
        chk("R8 ended", int'(filt_fail), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule